// File: doc/BRIEF.md
# System Management Interrupt Controller

This block decides when a processor core enters and leaves system management mode. It watches an active-low request pin and remembers each request as a falling edge, not as a level. A request it has remembered waits until the core signals an instruction boundary. At that boundary it outranks pending NMI and INTR. When the block takes a request, it pulses an entry strobe and asks the core to save its registers. It then holds an active-low mode status until the core executes its resume instruction or a hard reset arrives.

While the mode is active, the block masks soft-reset requests, so a soft reset cannot pull the core out of the mode. A request edge that arrives during the mode is kept. It is served at the first boundary after the resume. The block also gives an interrupt-select code, so the core's dispatch logic knows which source wins at the current boundary.

Top module: `smm_irq_ctrl`

## Requirements
- R1: The request pin passes through SYNC_STAGES flops, 2 by default. Once a low level has been sampled, the entry pulse appears three clock edges later if the boundary strobe is held high.
- R2: Only a high-to-low transition of the synchronised pin makes a request. A pin that stays low after a serviced request raises no further entry.
- R3: The synchronised pin may go high for at least two clocks and then low for at least two clocks. Such a sequence always produces one recognised request.
- R4: A pending request is taken only in a cycle where the boundary strobe is high. With the strobe low, the request stays pending and no entry pulse occurs.
- R5: While boundary is high, int_sel gives the source that wins at that boundary. The encoding is 2'b11 for a pending request outside the mode, 2'b10 for NMI, 2'b01 for INTR and 2'b00 for none, and the sources rank in that order. With boundary low, int_sel is 2'b00.
- R6: On entry, enter_pulse is high for exactly one cycle, and smm_act_n goes low in that same cycle. save_req is a one-cycle pulse SAVE_DELAY cycles after enter_pulse; the default SAVE_DELAY is 1.
- R7: smm_act_n stays low until the edge that samples resume_stb high, or until hard_rst. After that edge it is high.
- R8: soft_rst_out follows soft_rst_req while smm_act_n is high. It is 0 while smm_act_n is low.
- R9: A falling edge that arrives while in the mode is held pending. It is taken at the first boundary after the resume, and never before it.
- R10: After hard reset: smm_act_n is 1; enter_pulse, save_req and soft_rst_out are 0; int_sel is 2'b00; no request is pending. The synchroniser flops reset high, so a pin held low through reset counts as one request.
- R11: The pending request clears when the entry is taken, so one edge gives exactly one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Asynchronous hard reset, active high |
| smi_pin_n | input | 1 | Active-low management interrupt request |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| nmi_pend | input | 1 | Core has a pending NMI |
| intr_pend | input | 1 | Core has a pending maskable interrupt |
| resume_stb | input | 1 | Core executed the resume instruction |
| soft_rst_req | input | 1 | Soft-reset request |
| enter_pulse | output | 1 | One-cycle strobe on mode entry |
| save_req | output | 1 | One-cycle register-save request |
| smm_act_n | output | 1 | Active-low mode status, always driven |
| int_sel | output | 2 | Winning interrupt source at this boundary |
| soft_rst_out | output | 1 | Soft reset after masking by the mode |

## Verification
int_sel and soft_rst_out are combinational, so they change in the same cycle as their inputs. enter_pulse and smm_act_n change one edge after the boundary cycle that takes a request. save_req follows enter_pulse by one more edge, and a pin fall reaches the pending flag two edges after it is first sampled. The bench drives inputs just after each rising edge. It compares every output against its cycle model at the falling edge. Directed checks count edges from a stimulus to the edge where a result is due, and they check the cycle before as well.

// File: rtl/smm_irq_pkg.sv
package smm_irq_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'b00,
      SEL_INTR = 2'b01,
      SEL_NMI  = 2'b10,
      SEL_SMI  = 2'b11
   } irq_sel_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MAX_SAVE_DELAY  = 1;
endpackage

// File: rtl/smm_pin_sync.sv
module smm_pin_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic hard_rst,
   input  logic pin_n,
   output logic fall
);
   import smm_irq_pkg::*;

   localparam int unsigned LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("smm_pin_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or posedge hard_rst) begin
            if (hard_rst) chain_q[0] <= 1'b1;
            else          chain_q[0] <= pin_n;
         end
      end else begin : g_next
         always_ff @(posedge clk or posedge hard_rst) begin
            if (hard_rst) chain_q[i] <= 1'b1;
            else          chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or posedge hard_rst) begin
      if (hard_rst) prev_q <= 1'b1;
      else          prev_q <= chain_q[LAST];
   end

   assign fall = prev_q & ~chain_q[LAST];
endmodule

// File: rtl/smm_pend_arb.sv
module smm_pend_arb (
   input  logic                    clk,
   input  logic                    hard_rst,
   input  logic                    fall,
   input  logic                    boundary,
   input  logic                    in_mode,
   input  logic                    nmi_pend,
   input  logic                    intr_pend,
   output logic                    take,
   output smm_irq_pkg::irq_sel_e   sel
);
   import smm_irq_pkg::*;

   logic pend_q;
   logic smi_ready;

   assign smi_ready = pend_q & ~in_mode;
   assign take      = boundary & smi_ready;

   always_ff @(posedge clk or posedge hard_rst) begin
      if (hard_rst)  pend_q <= 1'b0;
      else if (fall) pend_q <= 1'b1;
      else if (take) pend_q <= 1'b0;
   end

   always_comb begin
      sel = SEL_NONE;
      if (boundary) begin
         if (smi_ready)      sel = SEL_SMI;
         else if (nmi_pend)  sel = SEL_NMI;
         else if (intr_pend) sel = SEL_INTR;
      end
   end
endmodule

// File: rtl/smm_mode_fsm.sv
module smm_mode_fsm #(
   parameter int unsigned SAVE_DELAY = 1
) (
   input  logic clk,
   input  logic hard_rst,
   input  logic take,
   input  logic resume_stb,
   input  logic soft_rst_req,
   output logic in_mode,
   output logic enter_pulse,
   output logic save_req,
   output logic soft_rst_out
);
   import smm_irq_pkg::*;

   if (SAVE_DELAY > MAX_SAVE_DELAY) begin : g_bad_delay
      $error("smm_mode_fsm: SAVE_DELAY must be 0 or 1");
   end

   logic mode_q;
   logic enter_q;

   always_ff @(posedge clk or posedge hard_rst) begin
      if (hard_rst) begin
         mode_q  <= 1'b0;
         enter_q <= 1'b0;
      end else begin
         enter_q <= take;
         if (take)            mode_q <= 1'b1;
         else if (resume_stb) mode_q <= 1'b0;
      end
   end

   if (SAVE_DELAY == 0) begin : g_save_now
      assign save_req = enter_q;
   end else begin : g_save_late
      logic save_q;
      always_ff @(posedge clk or posedge hard_rst) begin
         if (hard_rst) save_q <= 1'b0;
         else          save_q <= enter_q;
      end
      assign save_req = save_q;
   end

   assign in_mode      = mode_q;
   assign enter_pulse  = enter_q;
   assign soft_rst_out = soft_rst_req & ~mode_q;
endmodule

// File: rtl/smm_irq_ctrl.sv
module smm_irq_ctrl #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SAVE_DELAY  = 1
) (
   input  logic       clk,
   input  logic       hard_rst,
   input  logic       smi_pin_n,
   input  logic       boundary,
   input  logic       nmi_pend,
   input  logic       intr_pend,
   input  logic       resume_stb,
   input  logic       soft_rst_req,
   output logic       enter_pulse,
   output logic       save_req,
   output logic       smm_act_n,
   output logic [1:0] int_sel,
   output logic       soft_rst_out
);
   import smm_irq_pkg::*;

   logic     fall;
   logic     take;
   logic     in_mode;
   irq_sel_e sel;

   smm_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .hard_rst (hard_rst),
      .pin_n    (smi_pin_n),
      .fall     (fall)
   );

   smm_pend_arb arb_i (
      .clk       (clk),
      .hard_rst  (hard_rst),
      .fall      (fall),
      .boundary  (boundary),
      .in_mode   (in_mode),
      .nmi_pend  (nmi_pend),
      .intr_pend (intr_pend),
      .take      (take),
      .sel       (sel)
   );

   smm_mode_fsm #(.SAVE_DELAY(SAVE_DELAY)) fsm_i (
      .clk          (clk),
      .hard_rst     (hard_rst),
      .take         (take),
      .resume_stb   (resume_stb),
      .soft_rst_req (soft_rst_req),
      .in_mode      (in_mode),
      .enter_pulse  (enter_pulse),
      .save_req     (save_req),
      .soft_rst_out (soft_rst_out)
   );

   assign smm_act_n = ~in_mode;
   assign int_sel   = sel;
endmodule

// File: rtl/smm_irq_chk.sv
module smm_irq_chk #(
   parameter int unsigned SAVE_DELAY = 1
) (
   input logic       clk,
   input logic       hard_rst,
   input logic       boundary,
   input logic       resume_stb,
   input logic       enter_pulse,
   input logic       save_req,
   input logic       smm_act_n,
   input logic [1:0] int_sel,
   input logic       soft_rst_out
);
   AST_ENTER_ONE_CYCLE: assert property (@(posedge clk) disable iff (hard_rst)
      enter_pulse |=> !enter_pulse); // R6
   AST_ENTER_SETS_ACT: assert property (@(posedge clk) disable iff (hard_rst)
      enter_pulse |-> !smm_act_n); // R6
   AST_ENTER_AT_BOUNDARY: assert property (@(posedge clk) disable iff (hard_rst)
      !boundary |=> !enter_pulse); // R4
   AST_ACT_STICKY: assert property (@(posedge clk) disable iff (hard_rst)
      (!smm_act_n && !resume_stb) |=> !smm_act_n); // R7
   AST_RESUME_EXITS: assert property (@(posedge clk) disable iff (hard_rst)
      (!smm_act_n && resume_stb) |=> smm_act_n); // R7
   AST_NO_SOFT_RST_IN_MODE: assert property (@(posedge clk) disable iff (hard_rst)
      !smm_act_n |-> !soft_rst_out); // R8
   AST_NO_REENTRY_IN_MODE: assert property (@(posedge clk) disable iff (hard_rst)
      !smm_act_n |=> !enter_pulse); // R9
   AST_IDLE_SEL: assert property (@(posedge clk) disable iff (hard_rst)
      !boundary |-> (int_sel == 2'b00)); // R5

   if (SAVE_DELAY == 0) begin : g_save_now
      AST_SAVE_WITH_ENTER: assert property (@(posedge clk) disable iff (hard_rst)
         enter_pulse |-> save_req); // R6
   end else begin : g_save_late
      AST_SAVE_AFTER_ENTER: assert property (@(posedge clk) disable iff (hard_rst)
         enter_pulse |=> save_req); // R6
   end
endmodule

bind smm_irq_ctrl smm_irq_chk #(.SAVE_DELAY(SAVE_DELAY)) chk_i (
   .clk          (clk),
   .hard_rst     (hard_rst),
   .boundary     (boundary),
   .resume_stb   (resume_stb),
   .enter_pulse  (enter_pulse),
   .save_req     (save_req),
   .smm_act_n    (smm_act_n),
   .int_sel      (int_sel),
   .soft_rst_out (soft_rst_out)
);

// File: tb/smm_irq_ctrl_tb.sv
module smm_irq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       hard_rst = 1'b1;
   logic       smi_pin_n = 1'b1;
   logic       boundary = 1'b0;
   logic       nmi_pend = 1'b0;
   logic       intr_pend = 1'b0;
   logic       resume_stb = 1'b0;
   logic       soft_rst_req = 1'b0;
   logic       enter_pulse, save_req, smm_act_n, soft_rst_out;
   logic [1:0] int_sel;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   smm_irq_ctrl dut_i (
      .clk(clk), .hard_rst(hard_rst), .smi_pin_n(smi_pin_n), .boundary(boundary),
      .nmi_pend(nmi_pend), .intr_pend(intr_pend), .resume_stb(resume_stb),
      .soft_rst_req(soft_rst_req), .enter_pulse(enter_pulse), .save_req(save_req),
      .smm_act_n(smm_act_n), .int_sel(int_sel), .soft_rst_out(soft_rst_out)
   );

   // behavioural reference model, updated at every rising edge
   bit m_samples[$];
   bit m_mode, m_pend, m_enter, m_save;

   always @(posedge clk) begin
      bit s2, prv, fell, tk;
      if (hard_rst) begin
         m_samples = '{1'b1, 1'b1, 1'b1};
         m_mode = 0; m_pend = 0; m_enter = 0; m_save = 0;
      end else begin
         s2   = m_samples[1];
         prv  = m_samples[2];
         fell = prv && !s2;
         tk   = boundary && m_pend && !m_mode;
         m_save  = m_enter;
         m_enter = tk;
         if (fell)    m_pend = 1;
         else if (tk) m_pend = 0;
         if (tk)              m_mode = 1;
         else if (resume_stb) m_mode = 0;
         m_samples.push_front(smi_pin_n);
         void'(m_samples.pop_back());
      end
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      int esel;
      if (!hard_rst && !done) begin
         esel = 0;
         if (boundary) begin
            if (m_pend && !m_mode) esel = 3;
            else if (nmi_pend)     esel = 2;
            else if (intr_pend)    esel = 1;
         end
         check(enter_pulse == m_enter, "R6 enter_pulse vs model", enter_pulse, m_enter);
         check(save_req == m_save, "R6 save_req vs model", save_req, m_save);
         check(smm_act_n == !m_mode, "R7 smm_act_n vs model", smm_act_n, !m_mode);
         check(int_sel == esel, "R5 int_sel vs model", int_sel, esel);
         check(soft_rst_out == (soft_rst_req && !m_mode), "R8 soft_rst_out vs model",
               soft_rst_out, soft_rst_req && !m_mode);
      end
   end

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic do_reset();
      hard_rst = 1'b1;
      step(2);
      hard_rst = 1'b0;
      step(1);
   endtask

   task automatic resume();
      resume_stb = 1'b1;
      step(1);
      resume_stb = 1'b0;
   endtask

   task automatic fresh_edge();
      smi_pin_n = 1'b1;
      step(3);
      smi_pin_n = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      do_reset();
      // R10 reset state
      check(smm_act_n == 1 && enter_pulse == 0 && save_req == 0 && int_sel == 0 &&
            soft_rst_out == 0, "R10 reset outputs", {smm_act_n, enter_pulse, save_req}, 3'b100);
      boundary = 1'b1;
      step(3);
      check(enter_pulse == 0, "R10 no pending after reset", enter_pulse, 0);

      // R1 / R3: high two, low two -> entry on third edge after first low sample
      smi_pin_n = 1'b1;
      step(3);
      smi_pin_n = 1'b0;
      step(3);
      check(enter_pulse == 0, "R1 entry not early", enter_pulse, 0);
      step(1);
      check(enter_pulse == 1, "R1 entry after sync latency", enter_pulse, 1);
      check(smm_act_n == 0, "R3 request recognised", smm_act_n, 0);
      step(1);
      check(save_req == 1 && enter_pulse == 0, "R6 save after enter", save_req, 1);

      // R7 sticky, then resume
      step(5);
      check(smm_act_n == 0, "R7 sticky status", smm_act_n, 0);
      resume();
      check(smm_act_n == 1, "R7 exit on resume", smm_act_n, 1);

      // R2 / R11: pin stays low, no re-entry
      step(8);
      check(smm_act_n == 1 && enter_pulse == 0, "R2 level gives no re-entry", smm_act_n, 1);
      check(enter_pulse == 0, "R11 pending cleared on entry", enter_pulse, 0);

      // R4: pending held while no boundary
      boundary = 1'b0;
      fresh_edge();
      step(8);
      check(smm_act_n == 1, "R4 no entry without boundary", smm_act_n, 1);
      boundary = 1'b1;
      nmi_pend = 1'b1;
      intr_pend = 1'b1;
      #1;
      check(int_sel == 2'b11, "R5 SMI beats NMI and INTR", int_sel, 3);
      step(1);
      check(enter_pulse == 1, "R4 entry one edge after boundary", enter_pulse, 1);
      check(int_sel == 2'b10, "R5 NMI wins in mode", int_sel, 2);
      nmi_pend = 1'b0;
      #1;
      check(int_sel == 2'b01, "R5 INTR alone", int_sel, 1);
      intr_pend = 1'b0;

      // R8 soft reset masked in mode
      soft_rst_req = 1'b1;
      #1;
      check(soft_rst_out == 0, "R8 soft reset masked", soft_rst_out, 0);

      // R9: edge in mode held until resume
      fresh_edge();
      step(8);
      check(enter_pulse == 0 && smm_act_n == 0, "R9 no entry while in mode", enter_pulse, 0);
      resume();
      check(soft_rst_out == 1, "R8 soft reset passes outside mode", soft_rst_out, 1);
      soft_rst_req = 1'b0;
      check(enter_pulse == 0, "R9 not on resume edge", enter_pulse, 0);
      step(1);
      check(enter_pulse == 1, "R9 entry at first boundary after resume", enter_pulse, 1);

      // R7 hard reset exits the mode
      step(2);
      hard_rst = 1'b1;
      #1;
      check(smm_act_n == 1, "R7 hard reset exits mode", smm_act_n, 1);
      smi_pin_n = 1'b1;
      step(2);
      hard_rst = 1'b0;
      step(4);
      check(smm_act_n == 1, "R10 idle after reset", smm_act_n, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule